// File: doc/BRIEF.md
# Equality-Run Polarity Switching Detector

This block samples two single-bit inputs on every rising clock edge and drives one output bit. At first the output goes high when the two inputs disagree, so it computes their exclusive OR. The block also counts how many samples in a row have had both inputs equal. When that count reaches a set run length (three by default), the block changes polarity. From the next clock edge on, the output goes high when the two inputs agree, so it computes their exclusive NOR.

The reversed polarity is sticky. Only a synchronous reset, active low, brings the block back to the exclusive-OR rule. The output is a combinational function of the registered state and the present inputs, so it follows the inputs within the same cycle. The state is a single register of `$clog2(RUN_LEN+1)` bits:
- codes 0 to RUN_LEN-1 hold the current length of the equal run;
- code RUN_LEN marks reversed polarity.

Top module: `eqrun_polarity_switch`

## Requirements
- R1: A clock edge with `rst_n` low sets the state to run count 0 in normal polarity. After that edge, `y` equals `in_a XOR in_b`.
- R2: In normal polarity, `y` is 1 when `in_a` and `in_b` differ and 0 when they are equal, in the same cycle as the inputs.
- R3: In normal polarity, an edge that samples `in_a == in_b` raises the run count by one. An edge that samples `in_a != in_b` clears the run count to 0.
- R4: On the cycle that presents the RUN_LEN-th consecutive equal sample (the third, by default), `y` still follows the exclusive-OR rule. The reversed rule applies from the following cycle.
- R5: In reversed polarity, `y` is 1 when `in_a` and `in_b` are equal and 0 when they differ.
- R6: Once reversed, the block stays reversed whatever the inputs are, until an edge samples `rst_n` low.
- R7: Starting from reset, feeding `in_a` = 1,1,1,0,1,0,1,0 and `in_b` = 1,0,1,0,1,1,1,0 produces `y` = 0,1,0,0,0,0,1,1.
- R8: A run of fewer than RUN_LEN equal samples, broken by a differing sample, does not reverse the polarity. A new run then needs the full RUN_LEN equal samples again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_a | input | 1 | First sampled input |
| in_b | input | 1 | Second sampled input |
| y | output | 1 | Exclusive OR of the inputs in normal polarity, exclusive NOR once reversed |

## Verification
The bench goes after the boundary of the run.

- A run of two equal samples followed by a difference must leave the polarity alone. A design that forgot to clear the count would reverse too early on a later run.
- The third equal sample itself must still use the exclusive-OR rule. A design that switched its output in the same cycle would invert `y` one cycle early.
- Stickiness is tested by feeding differing samples after the reversal. A design that reused the run counter would drop back to normal polarity.
- A reset applied from reversed polarity must bring back the exclusive-OR rule.

Random streams with occasional resets are compared against a bench reference model on every cycle.

// File: rtl/eqrun_pkg.sv
// Shared helpers for the equality-run polarity switching detector.
// Assumes the run length is at least 1.
package eqrun_pkg;

    // Width of the state register: run count codes plus one reversed code.
    function automatic int state_width(input int run_len);
        return (run_len < 1) ? 1 : $clog2(run_len + 1);
    endfunction

endpackage

// File: rtl/eqrun_seq.sv
// Sequential half of the detector. It holds one state register: codes
// 0..RUN_LEN-1 are the length of the current equal run, and code RUN_LEN is
// the sticky reversed polarity. Assumes synchronous active-low reset and
// inputs already synchronous to clk.
module eqrun_seq #(
    parameter int RUN_LEN = 3,
    parameter int SW      = eqrun_pkg::state_width(RUN_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_a,
    input  logic          in_b,
    output logic [SW-1:0] run_cnt,
    output logic          rev_mode
);
    localparam logic [SW-1:0] REV_CODE  = SW'(RUN_LEN);
    localparam logic [SW-1:0] LAST_CODE = SW'(RUN_LEN - 1);

    logic [SW-1:0] state_q;
    logic [SW-1:0] state_d;
    logic          same;

    // Purpose: compare the two inputs of the present sample.
    always_comb same = (in_a == in_b);

    // Purpose: next state - count the run, clear it, or lock the reversed code.
    always_comb begin
        state_d = state_q;
        if (state_q != REV_CODE) begin
            if (!same)
                state_d = '0;
            else if (state_q == LAST_CODE)
                state_d = REV_CODE;
            else
                state_d = state_q + 1'b1;
        end
    end

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign rev_mode = (state_q == REV_CODE);
    assign run_cnt  = state_q;
endmodule

// File: rtl/eqrun_decode.sv
// Output decode. It selects exclusive OR or exclusive NOR of the present
// inputs from the registered polarity bit. Purely combinational.
module eqrun_decode (
    input  logic in_a,
    input  logic in_b,
    input  logic rev_mode,
    output logic y
);
    // Purpose: invert the difference signal when the polarity is reversed.
    always_comb y = (in_a ^ in_b) ^ rev_mode;
endmodule

// File: rtl/eqrun_polarity_switch.sv
// Top of the equality-run polarity switching detector. It samples in_a and
// in_b on each rising edge and drives y as their exclusive OR until RUN_LEN
// consecutive equal samples are seen, and as their exclusive NOR from then on
// until reset. Assumes synchronous active-low reset.
module eqrun_polarity_switch #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic y
);
    localparam int SW = eqrun_pkg::state_width(RUN_LEN);

    logic [SW-1:0] run_cnt;
    logic          rev_mode;

    eqrun_seq #(.RUN_LEN(RUN_LEN), .SW(SW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_a     (in_a),
        .in_b     (in_b),
        .run_cnt  (run_cnt),
        .rev_mode (rev_mode)
    );

    eqrun_decode u_dec (
        .in_a     (in_a),
        .in_b     (in_b),
        .rev_mode (rev_mode),
        .y        (y)
    );
endmodule

// File: rtl/eqrun_checker.sv
// Property checker for the detector, attached to every instance by bind.
module eqrun_checker #(
    parameter int RUN_LEN = 3,
    parameter int SW      = eqrun_pkg::state_width(RUN_LEN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_a,
    input logic          in_b,
    input logic          y,
    input logic [SW-1:0] run_cnt,
    input logic          rev_mode
);
    localparam logic [SW-1:0] LAST_CODE = SW'(RUN_LEN - 1);

    // R1: an edge with rst_n low returns the block to run count 0 in normal polarity.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!rev_mode && run_cnt == '0));

    // R2: in normal polarity y is the exclusive OR of the inputs.
    a_r2_xor_rule: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_mode |-> (y == (in_a ^ in_b)));

    // R3: a differing sample in normal polarity clears the count.
    a_r3_diff_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!rev_mode && in_a != in_b) |=> (!rev_mode && run_cnt == '0));

    // R3: an equal sample below the last code raises the count by one.
    a_r3_equal_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (!rev_mode && in_a == in_b && run_cnt != LAST_CODE)
        |=> (run_cnt == $past(run_cnt) + 1'b1));

    // R4: the equal sample that completes the run reverses the polarity on the next edge.
    a_r4_switch_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!rev_mode && in_a == in_b && run_cnt == LAST_CODE) |=> rev_mode);

    // R5: in reversed polarity y is the exclusive NOR of the inputs.
    a_r5_xnor_rule: assert property (@(posedge clk) disable iff (!rst_n)
        rev_mode |-> (y == (in_a ~^ in_b)));

    // R6: reversed polarity is held until reset.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rev_mode |=> rev_mode);
endmodule

bind eqrun_polarity_switch eqrun_checker #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_a     (in_a),
    .in_b     (in_b),
    .y        (y),
    .run_cnt  (run_cnt),
    .rev_mode (rev_mode)
);

// File: tb/sim_eqrun_polarity_switch.sv
module sim_eqrun_polarity_switch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic y;

    int n_tests = 0;
    int n_fail  = 0;
    int m_cnt   = 0;
    bit m_rev   = 1'b0;
    bit done    = 1'b0;

    eqrun_polarity_switch #(.RUN_LEN(3)) u0 (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .y(y)
    );

    always #10 clk = ~clk;

    function automatic bit exp_y(input bit rev, input bit a, input bit b);
        return rev ? (a ~^ b) : (a ^ b);
    endfunction

    task automatic check(input string req, input bit exp);
        n_tests++;
        if (y !== exp) begin
            n_fail++;
            $display("FAIL %s: y=%b expected %b (a=%b b=%b)", req, y, exp, in_a, in_b);
        end
    endtask

    // Drive one sample at the falling edge, check y mid-cycle, update the model at the rising edge.
    task automatic step(input bit r, input bit a, input bit b, input string req, input bit do_chk);
        @(negedge clk);
        rst_n = r; in_a = a; in_b = b;
        #5;
        if (do_chk) check(req, exp_y(m_rev, a, b));
        @(posedge clk);
        if (!r) begin m_cnt = 0; m_rev = 1'b0; end
        else if (!m_rev) begin
            if (a != b) m_cnt = 0;
            else if (m_cnt == 2) m_rev = 1'b1;
            else m_cnt++;
        end
    endtask

    task automatic expect_val(input string req, input bit exp);
        #5; check(req, exp);
    endtask

    initial begin
        bit ea[8] = '{1,1,1,0,1,0,1,0};
        bit eb[8] = '{1,0,1,0,1,1,1,0};
        bit ey[8] = '{0,1,0,0,0,0,1,1};
        void'($urandom(32'h5EED_0042));
        step(0, 0, 0, "", 0);
        step(0, 1, 1, "", 0);
        // R1: after reset, equal inputs give 0 and differing inputs give 1.
        step(1, 1, 1, "R1", 1);
        step(0, 0, 1, "R1", 1);
        // R7: example stream, checked against the fixed expected output.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rst_n = 1'b1; in_a = ea[i]; in_b = eb[i];
            expect_val("R7", ey[i]);
            @(posedge clk);
        end
        m_rev = 1'b1; m_cnt = 0;
        // R6: differing samples after reversal keep the exclusive NOR rule.
        for (int i = 0; i < 6; i++) step(1, i[0], ~i[0], "R6", 1);
        step(1, 1, 1, "R5", 1);
        step(1, 0, 1, "R5", 1);
        // R1: reset taken from reversed polarity brings back exclusive OR.
        step(0, 0, 0, "R1", 0);
        step(1, 0, 1, "R1", 1);
        step(1, 1, 1, "R1", 1);
        // R8: two equal samples then a difference; the run must start again.
        step(0, 0, 0, "", 0);
        step(1, 1, 1, "R8", 1);
        step(1, 0, 0, "R8", 1);
        step(1, 1, 0, "R8", 1);
        step(1, 1, 1, "R8", 1);
        step(1, 0, 0, "R8", 1);
        // R4: the third equal sample still uses exclusive OR (equal gives 0).
        @(negedge clk); in_a = 1; in_b = 1;
        expect_val("R4", 1'b0);
        @(posedge clk);
        m_rev = 1'b1;
        // R4: the next cycle uses exclusive NOR.
        @(negedge clk); in_a = 0; in_b = 0;
        expect_val("R4", 1'b1);
        @(posedge clk);
        // R2/R3/R5: random streams with equal samples favoured and rare resets.
        step(0, 0, 0, "", 0);
        for (int i = 0; i < 2000; i++) begin
            bit a, b, r;
            a = 1'($urandom);
            b = ($urandom % 3 != 0) ? a : 1'($urandom);
            r = ($urandom % 50 != 0);
            step(r, a, b, m_rev ? "R5" : (m_cnt == 0 ? "R2" : "R3"), 1);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule